// File: doc/BRIEF.md
# Masked associative match memory

This block is a small content-addressable store of eight twelve-bit words. Every word is compared with a search value at the same time. A separate mask value selects which bit positions take part in the comparison. Each word carries a valid tag, and a word whose tag is clear never matches. The outcome of a search is captured in a match register that holds one bit per word.

Words are written and read by index. A write stores the data and sets the word's tag. An invalidate clears the tag of the addressed word and leaves its data in place. The search value and the mask sit in two load-enabled registers. A one-cycle search strobe copies the per-word comparison result into the match register on the next clock edge, and the register keeps that value until the next strobe.

Three outputs are derived from the match register: a flag that any word matched, the index of the lowest-numbered matching word, and the current contents of that word. The port-side operation is decoded into one of three named operations: OP_IDLE (nothing happens), OP_WRITE (store data and set the tag) and OP_INVAL (clear the tag). OP_WRITE takes priority over OP_INVAL.

Top module: `masked_match_mem`

## Requirements
- R1: After reset all tags are 0, every stored word reads as 0, the search and mask registers are 0, match_vec is 0, any_match is 0 and first_idx is 0.
- R2: With wr_en high, wr_data is stored into word wr_idx at the clock edge and that word's tag becomes 1. From the next cycle, rd_data and rd_tag show the stored data and tag for rd_idx.
- R3: With inv_en high and wr_en low, the tag of word wr_idx is cleared at the clock edge and its stored data stays unchanged. When wr_en and inv_en are both high, the write is performed and the tag ends at 1.
- R4: A word matches only if its tag is 1 and ((word XOR search) AND mask) is zero, so bit positions that hold 0 in the mask always count as equal.
- R5: When the mask register is all zeros, every word whose tag is 1 matches and every word whose tag is 0 does not.
- R6: match_vec bit i is word i's match result. It changes only at a clock edge where srch_go is high, and it holds through writes, invalidates and register loads.
- R7: any_match is 1 exactly when match_vec has at least one bit set.
- R8: first_idx is the lowest index whose match_vec bit is 1, and 0 when no bit is set. first_data is the current stored data of word first_idx.
- R9: A search uses the search register, mask register, tags and data as they stand before the edge where srch_go is sampled. A load or write in the same cycle affects only later searches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store wr_data into word wr_idx and set its tag |
| inv_en | input | 1 | Clear the tag of word wr_idx |
| wr_idx | input | 3 | Word index for write and invalidate |
| wr_data | input | 12 | Data to store |
| rd_idx | input | 3 | Word index for reading |
| rd_data | output | 12 | Stored data of word rd_idx |
| rd_tag | output | 1 | Tag of word rd_idx |
| arg_we | input | 1 | Load the search register from arg_in |
| arg_in | input | 12 | New search value |
| key_we | input | 1 | Load the mask register from key_in |
| key_in | input | 12 | New mask value, 1 = compare this bit |
| srch_go | input | 1 | One-cycle search strobe |
| match_vec | output | 8 | Match register, bit i for word i |
| any_match | output | 1 | At least one word matched |
| first_idx | output | 3 | Lowest matching word index |
| first_data | output | 12 | Stored data of word first_idx |

## Verification
The hardest cases to reach from the ports are coincidences. These are a search strobe in the same cycle as a search-value load or a word write, a write and an invalidate on the same word at once, and several equal words where some carry a cleared tag so that the lowest match is not the lowest equal word. The bench fills the memory with a computed pattern and then sweeps a grid of masks against every stored value and several unrelated values, both before and after invalidating chosen words. It then places equal words at chosen indices and fires the coincident operations in single cycles, with every expectation taken from its own model of the requirements.

// File: rtl/mmm_pkg.sv
package mmm_pkg;

    parameter int MMM_WORDS = 8;
    parameter int MMM_WIDTH = 12;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_INVAL = 2'd2
    } mmm_op_e;

endpackage

// File: rtl/mmm_word_cmp.sv
module mmm_word_cmp #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic [WIDTH-1:0] arg_i,
    input  logic [WIDTH-1:0] key_i,
    input  logic             valid_i,
    output logic             hit_o
);
    logic [WIDTH-1:0] diff;

    always_comb begin
        diff  = (word_i ^ arg_i) & key_i;
        hit_o = valid_i && (diff == '0);
    end
endmodule

// File: rtl/mmm_first_hit.sv
module mmm_first_hit #(
    parameter int WORDS = 8,
    parameter int IW    = 3
) (
    input  logic [WORDS-1:0] vec_i,
    output logic             found_o,
    output logic [IW-1:0]    idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/masked_match_mem.sv
module masked_match_mem
    import mmm_pkg::*;
#(
    parameter int WORDS = MMM_WORDS,
    parameter int WIDTH = MMM_WIDTH,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             inv_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_tag,
    input  logic             arg_we,
    input  logic [WIDTH-1:0] arg_in,
    input  logic             key_we,
    input  logic [WIDTH-1:0] key_in,
    input  logic             srch_go,
    output logic [WORDS-1:0] match_vec,
    output logic             any_match,
    output logic [IW-1:0]    first_idx,
    output logic [WIDTH-1:0] first_data
);

    logic [WIDTH-1:0] mem_q [WORDS];
    logic [WORDS-1:0] tag_q;
    logic [WIDTH-1:0] arg_q;
    logic [WIDTH-1:0] key_q;
    logic [WORDS-1:0] match_q;
    logic [WORDS-1:0] hit_now;
    mmm_op_e          op;

    // Port-side operation decode: a write outranks an invalidate.
    always_comb begin
        if (wr_en)       op = OP_WRITE;
        else if (inv_en) op = OP_INVAL;
        else             op = OP_IDLE;
    end

    // Tag bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            unique case (op)
                OP_WRITE: tag_q[wr_idx] <= 1'b1;
                OP_INVAL: tag_q[wr_idx] <= 1'b0;
                OP_IDLE:  tag_q         <= tag_q;
                default:  tag_q         <= tag_q;
            endcase
        end
    end

    // Word storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (op == OP_WRITE) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    // Search value and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0;
            key_q <= '0;
        end else begin
            if (arg_we) arg_q <= arg_in;
            if (key_we) key_q <= key_in;
        end
    end

    // One comparator per word
    for (genvar g = 0; g < WORDS; g++) begin : g_cmp
        mmm_word_cmp #(.WIDTH(WIDTH)) u_cmp (
            .word_i  (mem_q[g]),
            .arg_i   (arg_q),
            .key_i   (key_q),
            .valid_i (tag_q[g]),
            .hit_o   (hit_now[g])
        );
    end

    // Match register: loads only on the search strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       match_q <= '0;
        else if (srch_go) match_q <= hit_now;
    end

    mmm_first_hit #(.WORDS(WORDS), .IW(IW)) u_first (
        .vec_i   (match_q),
        .found_o (any_match),
        .idx_o   (first_idx)
    );

    always_comb begin
        match_vec  = match_q;
        first_data = mem_q[first_idx];
        rd_data    = mem_q[rd_idx];
        rd_tag     = tag_q[rd_idx];
    end

endmodule

// File: rtl/masked_match_chk.sv
module masked_match_chk #(
    parameter int WORDS = 8,
    parameter int WIDTH = 12,
    parameter int IW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             inv_en,
    input logic [IW-1:0]    wr_idx,
    input logic             srch_go,
    input logic [WORDS-1:0] tag_q,
    input logic [WIDTH-1:0] key_q,
    input logic [WORDS-1:0] match_vec,
    input logic             any_match,
    input logic [IW-1:0]    first_idx
);

    a_r2_write_sets_tag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tag_q[$past(wr_idx)]);

    a_r3_inval_clears_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !wr_en) |=> !tag_q[$past(wr_idx)]);

    a_r4_tag_gates_match: assert property (@(posedge clk) disable iff (!rst_n)
        srch_go |=> ((match_vec & ~$past(tag_q)) == '0));

    a_r5_empty_key_all_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_go && key_q == '0) |=> (match_vec == $past(tag_q)));

    a_r6_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_go |=> $stable(match_vec));

    a_r7_any_points_at_hit: assert property (@(posedge clk) disable iff (!rst_n)
        any_match |-> match_vec[first_idx]);

    a_r8_lowest_hit: assert property (@(posedge clk) disable iff (!rst_n)
        any_match |-> ((match_vec & ((WORDS'(1) << first_idx) - WORDS'(1))) == '0));

    a_r8_none_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !any_match |-> (first_idx == '0));

endmodule

bind masked_match_mem masked_match_chk #(.WORDS(WORDS), .WIDTH(WIDTH), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .inv_en    (inv_en),
    .wr_idx    (wr_idx),
    .srch_go   (srch_go),
    .tag_q     (tag_q),
    .key_q     (key_q),
    .match_vec (match_vec),
    .any_match (any_match),
    .first_idx (first_idx)
);

// File: tb/test_masked_match_mem.sv
`timescale 1ns/1ps
module test_masked_match_mem;

    localparam int W  = 8;
    localparam int N  = 12;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, inv_en = 1'b0;
    logic [IW-1:0] wr_idx = '0, rd_idx = '0;
    logic [N-1:0]  wr_data = '0, arg_in = '0, key_in = '0;
    logic          arg_we = 1'b0, key_we = 1'b0, srch_go = 1'b0;
    logic [N-1:0]  rd_data, first_data;
    logic          rd_tag, any_match;
    logic [W-1:0]  match_vec;
    logic [IW-1:0] first_idx;

    masked_match_mem i_masked_match_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .inv_en(inv_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_tag(rd_tag), .arg_we(arg_we),
        .arg_in(arg_in), .key_we(key_we), .key_in(key_in),
        .srch_go(srch_go), .match_vec(match_vec), .any_match(any_match),
        .first_idx(first_idx), .first_data(first_data)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_data [W];
    logic [W-1:0] m_tag;
    logic [W-1:0] m_match;

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [W-1:0] model_match(input logic [N-1:0] a, input logic [N-1:0] k);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W; i++)
            r[i] = m_tag[i] && (((m_data[i] ^ a) & k) == '0);
        return r;
    endfunction

    task automatic check_result(input string req);
        int fi = 0;
        for (int i = W - 1; i >= 0; i--) if (m_match[i]) fi = i;
        chk(req, "match_vec", int'(match_vec), int'(m_match));
        chk("R7", "any_match", int'(any_match), int'(m_match != '0));
        chk("R8", "first_idx", int'(first_idx), fi);
        chk("R8", "first_data", int'(first_data), int'(m_data[fi]));
    endtask

    task automatic do_write(input int idx, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_data[idx] = d; m_tag[idx] = 1'b1;
    endtask

    task automatic do_inval(input int idx);
        @(negedge clk);
        inv_en = 1'b1; wr_idx = IW'(idx);
        @(negedge clk);
        inv_en = 1'b0;
        m_tag[idx] = 1'b0;
    endtask

    task automatic do_search(input logic [N-1:0] a, input logic [N-1:0] k, input string req);
        @(negedge clk);
        arg_we = 1'b1; key_we = 1'b1; arg_in = a; key_in = k;
        @(negedge clk);
        arg_we = 1'b0; key_we = 1'b0; srch_go = 1'b1;
        @(negedge clk);
        srch_go = 1'b0;
        m_match = model_match(a, k);
        check_result(req);
    endtask

    task automatic check_reads(input string req);
        for (int i = 0; i < W; i++) begin
            rd_idx = IW'(i);
            #1;
            chk(req, "rd_data", int'(rd_data), int'(m_data[i]));
            chk(req, "rd_tag", int'(rd_tag), int'(m_tag[i]));
        end
    endtask

    task automatic sweep(input string req);
        logic [N-1:0] keys [9] = '{12'h000, 12'hFFF, 12'hF00, 12'h0F0, 12'h00F,
                                   12'h555, 12'hAAA, 12'h001, 12'h800};
        for (int k = 0; k < 9; k++) begin
            for (int i = 0; i < W; i++) do_search(m_data[i], keys[k], req);
            do_search(12'h000, keys[k], req);
            do_search(12'hFFF, keys[k], req);
            do_search(N'(k * 12'h2B7), keys[k], req);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < W; i++) m_data[i] = '0;
        m_tag = '0; m_match = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_result("R1");
        check_reads("R1");
        // R4: no tags set, so even an empty mask matches nothing
        do_search(12'h000, 12'h000, "R4");

        // R2: fill memory with a computed pattern
        for (int i = 0; i < W; i++) do_write(i, N'((i * 12'h19B + 12'h035) & 12'hFFF));
        check_reads("R2");

        // R4/R5: mask sweep over the full memory
        sweep("R4");

        // R3: invalidate words 2 and 5, data kept
        do_inval(2);
        do_inval(5);
        check_reads("R3");
        sweep("R5");

        // R3: write and invalidate in the same cycle, write wins
        @(negedge clk);
        wr_en = 1'b1; inv_en = 1'b1; wr_idx = 3'd5; wr_data = 12'h0C3;
        @(negedge clk);
        wr_en = 1'b0; inv_en = 1'b0;
        m_data[5] = 12'h0C3; m_tag[5] = 1'b1;
        check_reads("R3");

        // R8: equal words, lowest one invalid
        do_write(1, 12'h7E1);
        do_write(4, 12'h7E1);
        do_write(6, 12'h7E1);
        do_inval(1);
        do_search(12'h7E1, 12'hFFF, "R8");
        chk("R8", "first_idx dup", int'(first_idx), 4);

        // R6: match register holds across writes and loads; first_data follows storage
        do_write(4, 12'h123);
        @(negedge clk);
        arg_we = 1'b1; key_we = 1'b1; arg_in = 12'h000; key_in = 12'h000;
        @(negedge clk);
        arg_we = 1'b0; key_we = 1'b0;
        do_inval(6);
        check_result("R6");
        chk("R8", "first_data after rewrite", int'(first_data), 32'h123);

        // R9: load search value in the same cycle as the strobe
        do_search(12'h0C3, 12'hFFF, "R9");
        @(negedge clk);
        arg_we = 1'b1; arg_in = 12'h123; srch_go = 1'b1;
        @(negedge clk);
        arg_we = 1'b0; srch_go = 1'b0;
        m_match = model_match(12'h0C3, 12'hFFF);
        check_result("R9");

        // R9: write in the same cycle as the strobe sees old storage
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd0; wr_data = 12'h123; srch_go = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; srch_go = 1'b0;
        m_match = model_match(12'h123, 12'hFFF);
        m_data[0] = 12'h123; m_tag[0] = 1'b1;
        check_result("R9");
        // next search sees the new word 0
        do_search(12'h123, 12'hFFF, "R9");
        chk("R9", "first_idx new", int'(first_idx), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule